// File: doc/BRIEF.md
# Keyed Reset Watchdog Timer

This block is a watchdog counter for a power-management device. A watchdog counter, when it runs out, can reset the whole system. Software reaches it through a plain 16-bit register interface. The link that carries those accesses sits outside the block and is not part of it. Configuration is write-protected: the load and control registers accept writes only after a fixed 16-bit key has been written to a lock register. Writing any other value to the lock register protects the configuration again.

The 32-bit timeout is loaded through two 16-bit halves. Setting the run bit copies the combined value into a down-counter. The counter then steps down once per slow tick, a one-cycle strobe produced at 32768 Hz, so about 1638 ticks give a 50 ms timeout. Two enable inputs gate the block. The interface enable admits register writes. The work-clock enable admits ticks. When the count steps from one to zero, one of two things happens. If resets are enabled, a reset pulse of fixed width is driven on the system reset output. If resets are disabled, a sticky expiry flag is raised.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the block is locked (lock register 0xA0 reads bit0 = 1). Both load halves, the control register and the count read 0, and `sys_rst_o` is low.
- R2: While locked, writes to the load halves (0x80 low, 0x84 high) and to the control register (0x88) leave them unchanged.
- R3: Writing 0xE551 to 0xA0 clears the lock (bit0 reads 0). Writing any other value to 0xA0 sets it again.
- R4: A write to 0x88 with bit1 (run) = 1 while run was 0 loads the count with {high half, low half}. A write that keeps run at 1 does not reload.
- R5: While run is 1 and the count is not zero, each tick taken by the block lowers the count by one. The count reads at 0x90 (low) and 0x94 (high).
- R6: While run is 0, ticks leave the count unchanged.
- R7: With `if_en_i` low, register writes of every kind are ignored. With `clk_en_i` low, ticks are ignored.
- R8: When the count steps from 1 to 0 with bit3 (reset enable) set, `sys_rst_o` is high for exactly 4 clocks, starting on the edge that samples the expiring tick.
- R9: When the count steps from 1 to 0 with reset enable clear, bit4 of 0x88 (expired) becomes 1 and stays 1. `sys_rst_o` stays low. Further ticks keep the count at 0. A reloading run write clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_en_i | input | 1 | Interface enable; gates register writes |
| clk_en_i | input | 1 | Work-clock enable; gates ticks |
| tick_i | input | 1 | One-cycle strobe at the 32768 Hz rate |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write offset |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 12 | Register read offset |
| rd_data_o | output | 16 | Register read data (combinational) |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
A lock bit stuck open would let a locked write change the load or control readback in the very next read. A lock that fails to reopen would show the old values in the same way. A count that skips or misses a decrement shows up at the count offsets one tick later, and a wrong count also moves the expiry point. That in turn moves when `sys_rst_o` rises or when the expired flag sets, by a whole tick. A pulse counter with the wrong width or the wrong start shows up within a few clocks as the wrong number of high cycles on `sys_rst_o`.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int RUN_BIT   = 1;
   localparam int RSTEN_BIT = 3;
   localparam int EXP_BIT   = 4;
   localparam int LOCK_BIT  = 0;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_LOAD_LO,
      SEL_LOAD_HI,
      SEL_CTRL,
      SEL_LOCK,
      SEL_CNT_LO,
      SEL_CNT_HI
   } reg_sel_e;
endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
   import wdt_pkg::*;
#(
   parameter int          REG_W   = 16,
   parameter int          ADDR_W  = 12,
   parameter logic [11:0] OFF_LO  = 12'h080,
   parameter logic [11:0] OFF_HI  = 12'h084,
   parameter logic [11:0] OFF_CTL = 12'h088,
   parameter logic [11:0] OFF_LCK = 12'h0A0,
   parameter logic [15:0] KEY     = 16'hE551,
   localparam int         CNT_W   = 2 * REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              if_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              expire,
   output logic [REG_W-1:0]  load_lo,
   output logic [REG_W-1:0]  load_hi,
   output logic [CNT_W-1:0]  load_val,
   output logic              run,
   output logic              rst_en,
   output logic              expired,
   output logic              locked,
   output logic              reload,
   output logic              fire
);
   generate
      if (REG_W < 5)  begin : g_bad_w  $error("REG_W too narrow for control bits"); end
      if (REG_W > 16) begin : g_bad_k  $error("REG_W wider than the key"); end
      if (ADDR_W > 12) begin : g_bad_a $error("ADDR_W wider than offsets"); end
   endgenerate

   reg_sel_e   wsel;
   logic       wr_ok;
   logic       cfg_ok;

   always_comb begin
      wsel = SEL_NONE;
      if      (wr_addr == OFF_LO[ADDR_W-1:0])  wsel = SEL_LOAD_LO;
      else if (wr_addr == OFF_HI[ADDR_W-1:0])  wsel = SEL_LOAD_HI;
      else if (wr_addr == OFF_CTL[ADDR_W-1:0]) wsel = SEL_CTRL;
      else if (wr_addr == OFF_LCK[ADDR_W-1:0]) wsel = SEL_LOCK;
   end

   assign wr_ok    = wr_en && if_en;
   assign cfg_ok   = wr_ok && !locked;
   assign load_val = {load_hi, load_lo};
   assign reload   = cfg_ok && (wsel == SEL_CTRL) && wr_data[RUN_BIT] && !run;
   assign fire     = expire && rst_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b1;
      end else if (wr_ok && wsel == SEL_LOCK) begin
         locked <= (wr_data != KEY[REG_W-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_lo <= '0;
         load_hi <= '0;
         run     <= 1'b0;
         rst_en  <= 1'b0;
      end else if (cfg_ok) begin
         if (wsel == SEL_LOAD_LO) load_lo <= wr_data;
         if (wsel == SEL_LOAD_HI) load_hi <= wr_data;
         if (wsel == SEL_CTRL) begin
            run    <= wr_data[RUN_BIT];
            rst_en <= wr_data[RSTEN_BIT];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  expired <= 1'b0;
      else if (reload)             expired <= 1'b0;
      else if (expire && !rst_en)  expired <= 1'b1;
   end

   p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && wr_en && wsel == SEL_LOAD_LO) |=> $stable(load_lo));
   p_locked_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && wr_en && wsel == SEL_CTRL) |=> ($stable(run) && $stable(rst_en)));
   p_key_unlock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && if_en && wsel == SEL_LOCK && wr_data == KEY[REG_W-1:0]) |=> !locked);
   p_no_if_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !if_en |=> ($stable(locked) && $stable(load_lo) && $stable(load_hi)));
   p_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expired) |-> !rst_en);
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             run,
   input  logic             reload,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic step;

   generate
      if (CNT_W < 2) begin : g_bad_cnt $error("CNT_W must be at least 2"); end
   endgenerate

   assign step   = tick_en && run && (cnt != '0) && !reload;
   assign expire = step && (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (reload) cnt <= load_val;
      else if (step)   cnt <= cnt - ONE;
   end

   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (cnt == $past(load_val)));
   p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && run && !reload && cnt != '0) |=> (cnt == $past(cnt) - ONE));
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !reload) |=> $stable(cnt));
   p_zero_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !reload) |=> (cnt == '0));
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
   parameter int PULSE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic rst_out
);
   generate
      if (PULSE_CYC < 1) begin : g_bad_p
         $error("PULSE_CYC must be positive");
      end
      if (PULSE_CYC == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rst_out <= 1'b0;
            else        rst_out <= fire;
         end
      end else begin : g_count
         localparam int PW = $clog2(PULSE_CYC + 1);
         localparam logic [PW-1:0] WIDTH = PW'(PULSE_CYC);
         logic [PW-1:0] left;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            left <= '0;
            else if (fire)         left <= WIDTH;
            else if (left != '0)   left <= left - PW'(1);
         end
         assign rst_out = (left != '0);

         p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
            left <= WIDTH);
      end
   endgenerate

   p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> rst_out);
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
   import wdt_pkg::*;
#(
   parameter int          REG_W     = 16,
   parameter int          ADDR_W    = 12,
   parameter int          PULSE_CYC = 4,
   parameter logic [11:0] OFF_LO    = 12'h080,
   parameter logic [11:0] OFF_HI    = 12'h084,
   parameter logic [11:0] OFF_CTL   = 12'h088,
   parameter logic [11:0] OFF_CLO   = 12'h090,
   parameter logic [11:0] OFF_CHI   = 12'h094,
   parameter logic [11:0] OFF_LCK   = 12'h0A0,
   parameter logic [15:0] KEY       = 16'hE551
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              if_en_i,
   input  logic              clk_en_i,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [REG_W-1:0]  wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [REG_W-1:0]  rd_data_o,
   output logic              sys_rst_o
);
   localparam int CNT_W = 2 * REG_W;

   logic [REG_W-1:0] load_lo, load_hi;
   logic [CNT_W-1:0] load_val, cnt;
   logic             run, rst_en, expired, locked, reload, fire, expire;
   reg_sel_e         rsel;

   wdt_ctrl_regs #(
      .REG_W(REG_W), .ADDR_W(ADDR_W), .OFF_LO(OFF_LO), .OFF_HI(OFF_HI),
      .OFF_CTL(OFF_CTL), .OFF_LCK(OFF_LCK), .KEY(KEY)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .if_en(if_en_i), .wr_en(wr_en_i),
      .wr_addr(wr_addr_i), .wr_data(wr_data_i), .expire(expire),
      .load_lo(load_lo), .load_hi(load_hi), .load_val(load_val),
      .run(run), .rst_en(rst_en), .expired(expired), .locked(locked),
      .reload(reload), .fire(fire)
   );

   wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_i && clk_en_i), .run(run),
      .reload(reload), .load_val(load_val), .cnt(cnt), .expire(expire)
   );

   wdt_rst_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(fire), .rst_out(sys_rst_o)
   );

   always_comb begin
      rsel = SEL_NONE;
      if      (rd_addr_i == OFF_LO[ADDR_W-1:0])  rsel = SEL_LOAD_LO;
      else if (rd_addr_i == OFF_HI[ADDR_W-1:0])  rsel = SEL_LOAD_HI;
      else if (rd_addr_i == OFF_CTL[ADDR_W-1:0]) rsel = SEL_CTRL;
      else if (rd_addr_i == OFF_LCK[ADDR_W-1:0]) rsel = SEL_LOCK;
      else if (rd_addr_i == OFF_CLO[ADDR_W-1:0]) rsel = SEL_CNT_LO;
      else if (rd_addr_i == OFF_CHI[ADDR_W-1:0]) rsel = SEL_CNT_HI;
   end

   always_comb begin
      rd_data_o = '0;
      case (rsel)
         SEL_LOAD_LO: rd_data_o = load_lo;
         SEL_LOAD_HI: rd_data_o = load_hi;
         SEL_CTRL: begin
            rd_data_o[RUN_BIT]   = run;
            rd_data_o[RSTEN_BIT] = rst_en;
            rd_data_o[EXP_BIT]   = expired;
         end
         SEL_LOCK:   rd_data_o[LOCK_BIT] = locked;
         SEL_CNT_LO: rd_data_o = cnt[REG_W-1:0];
         SEL_CNT_HI: rd_data_o = cnt[CNT_W-1:REG_W];
         default:    rd_data_o = '0;
      endcase
   end

   p_rst_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_o) |-> rst_en);
   p_no_exp_if_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !run) |=> !sys_rst_o || $past(sys_rst_o));
endmodule

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;
   localparam int PERIOD = 10;
   localparam logic [11:0] A_LO = 12'h080, A_HI = 12'h084, A_CTL = 12'h088,
                           A_CLO = 12'h090, A_CHI = 12'h094, A_LCK = 12'h0A0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        if_en = 1'b1, clk_en = 1'b1, tick = 1'b0, wr_en = 1'b0;
   logic [11:0] wr_addr = '0, rd_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        sys_rst;

   int checks = 0;
   int failures = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #(PERIOD/2) clk = ~clk;

   wdt_keyed u_dut (
      .clk(clk), .rst_n(rst_n), .if_en_i(if_en), .clk_en_i(clk_en),
      .tick_i(tick), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .sys_rst_o(sys_rst)
   );

   // monitor: compares queued expectations after each clock edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() != 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
               failures++;
               $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
            end
         end
      end
   end

   task automatic rd_expect(input logic [11:0] a, input logic [15:0] e, input string t);
      @(negedge clk);
      rd_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      wait (exp_q.size() == 0);
   endtask

   task automatic wr(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic chk_bit(input logic act, input logic e, input string t);
      checks++;
      if (act !== e) begin
         failures++;
         $display("FAIL %s: value=%b expected=%b", t, act, e);
      end
   endtask

   task automatic count_rst(input int e, input string t);
      int highs = 0;
      for (int i = 0; i < 10; i++) begin
         if (sys_rst) highs++;
         @(negedge clk);
      end
      checks++;
      if (highs != e) begin
         failures++;
         $display("FAIL %s: high cycles=%0d expected=%0d", t, highs, e);
      end
   endtask

   initial begin
      #(PERIOD * 100000);
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_expect(A_LCK, 16'h0001, "R1 lock after reset");
      rd_expect(A_CTL, 16'h0000, "R1 ctrl after reset");
      rd_expect(A_CLO, 16'h0000, "R1 count after reset");
      chk_bit(sys_rst, 1'b0, "R1 reset output idle");
      // R2 locked writes ignored
      wr(A_LO, 16'h0005);
      wr(A_CTL, 16'h000A);
      rd_expect(A_LO, 16'h0000, "R2 load low locked");
      rd_expect(A_CTL, 16'h0000, "R2 ctrl locked");
      // R3 unlock and relock
      wr(A_LCK, 16'hE551);
      rd_expect(A_LCK, 16'h0000, "R3 unlocked by key");
      wr(A_LO, 16'h0003);
      wr(A_HI, 16'h0001);
      rd_expect(A_HI, 16'h0001, "R3 load high after unlock");
      wr(A_LCK, 16'h1234);
      rd_expect(A_LCK, 16'h0001, "R3 relocked by wrong value");
      wr(A_LO, 16'h0007);
      rd_expect(A_LO, 16'h0003, "R3 write ignored after relock");
      // R7 interface enable
      wr(A_LCK, 16'hE551);
      if_en = 1'b0;
      wr(A_CTL, 16'h0002);
      if_en = 1'b1;
      rd_expect(A_CTL, 16'h0000, "R7 write ignored without if_en");
      // R4 reload on run
      wr(A_CTL, 16'h0002);
      rd_expect(A_CLO, 16'h0003, "R4 count low reloaded");
      rd_expect(A_CHI, 16'h0001, "R4 count high reloaded");
      // R7 clock enable
      clk_en = 1'b0;
      do_tick();
      clk_en = 1'b1;
      rd_expect(A_CLO, 16'h0003, "R7 tick ignored without clk_en");
      // R5 decrement
      do_tick();
      do_tick();
      rd_expect(A_CLO, 16'h0001, "R5 two ticks decrement");
      // R4 no reload while running
      wr(A_LO, 16'h0009);
      wr(A_CTL, 16'h0002);
      rd_expect(A_CLO, 16'h0001, "R4 no reload when already running");
      // R6 hold
      wr(A_CTL, 16'h0000);
      do_tick();
      rd_expect(A_CLO, 16'h0001, "R6 hold while stopped");
      rd_expect(A_CHI, 16'h0001, "R6 hold high half");
      // R9 expiry without reset enable
      wr(A_HI, 16'h0000);
      wr(A_LO, 16'h0003);
      wr(A_CTL, 16'h0002);
      do_tick(); do_tick(); do_tick();
      chk_bit(sys_rst, 1'b0, "R9 no reset pulse");
      rd_expect(A_CTL, 16'h0012, "R9 expired flag set");
      rd_expect(A_CLO, 16'h0000, "R9 count at zero");
      do_tick();
      rd_expect(A_CLO, 16'h0000, "R9 count stays zero");
      rd_expect(A_CTL, 16'h0012, "R9 flag sticky");
      // R8 expiry with reset enable
      wr(A_CTL, 16'h0000);
      wr(A_CTL, 16'h000A);
      rd_expect(A_CTL, 16'h000A, "R9 flag cleared by reload");
      do_tick(); do_tick();
      chk_bit(sys_rst, 1'b0, "R8 no pulse before expiry");
      do_tick();
      count_rst(4, "R8 pulse width");
      rd_expect(A_CTL, 16'h000A, "R8 no expired flag when resetting");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule